// File: doc/BRIEF.md
# Hit and Miss Event Counter Bank

This block keeps a bank of event counters for a cache. Each event presented to it carries a hit or miss flag, a command index, a writeback flag, a requester id and a device flag. The device flag marks an access that comes without a requester id. The block picks a requester bucket for the event and increments one counter. That counter is chosen by the outcome (hit or miss), by the command index and by the bucket. Software reads any counter back through a registered read port and derives ratios and averages from the raw counts.

A miss-limit countdown is also part of the block. A nonzero limit is loaded, and after that each miss takes one off it. The miss that brings it to zero raises a single-cycle stop pulse. The countdown is a small state machine with three states. LIM_OFF means the countdown is disabled. LIM_RUN means it is armed and counting. LIM_DONE means the stop has already been raised. A load moves any state to LIM_RUN when the value is nonzero and to LIM_OFF when it is zero. LIM_RUN moves to LIM_DONE on the miss that exhausts the count. LIM_OFF and LIM_DONE stay where they are until the next load.

Top module: `stat_hitmiss_counter`

## Requirements
- R1: An event with the writeback flag set is counted in bucket 0, for hits and misses alike, whatever its id and device flag.
- R2: An event without the writeback flag but with the device flag set is counted in the extra bucket, whose index is NUM_REQ.
- R3: Every other event is counted in bucket (requester id mod NUM_REQ), so ids at or above NUM_REQ wrap.
- R4: Hits and misses have separate counters for each command index and each bucket. A valid event adds one to exactly one counter at the clock edge where it is sampled. An event whose command index is at or above NUM_CMD changes no counter.
- R5: A counter that has reached its all-ones value stays there when further events arrive.
- R6: A read request samples rd_miss (1 = miss counter), rd_cmd and rd_bucket. On the next cycle rd_valid is high and rd_data holds that counter. A command or bucket outside the bank reads as zero.
- R7: While the countdown is in LIM_RUN, each miss event decrements it and hits leave it alone. The miss that takes it to zero drives stop_pulse high for exactly the one cycle after that miss is sampled.
- R8: A limit of zero disables the countdown, and no number of misses then raises stop_pulse.
- R9: After a stop, further misses raise no pulse until a nonzero limit is loaded again, and that load re-arms the countdown.
- R10: After reset every counter reads zero, rd_valid and stop_pulse are low, and the countdown is in LIM_OFF.
- R11: A limit load in the same cycle as a miss takes precedence. That miss does not consume any of the new limit, but it is still counted in the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_miss | input | 1 | 1 = miss, 0 = hit |
| ev_cmd | input | CMD_W | Command index of the event |
| ev_wb | input | 1 | Event is a writeback |
| ev_dev | input | 1 | Event has no requester id (device access) |
| ev_id | input | ID_W | Requester id |
| lim_load | input | 1 | Load the miss limit |
| lim_value | input | LIMIT_W | Limit to load; zero disables |
| rd_en | input | 1 | Read request |
| rd_miss | input | 1 | Read the miss (1) or hit (0) counter |
| rd_cmd | input | CMD_W | Command index to read |
| rd_bucket | input | BKT_W | Bucket to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Counter value |
| stop_pulse | output | 1 | One-cycle stop request |

## Verification
On every cycle the assertions check the bucket that the selector picks against the writeback and device flags. They also check that a read answer follows each request one cycle later, that the stop pulse lasts one cycle and comes only from an armed countdown that saw a miss, and that LIM_DONE and LIM_OFF hold until a load. Exact counter values depend on the history of events. They are visible only through the bench's scenarios: a seeded random event stream whose counts are compared with a reference model, saturation, wrap of ids, ignored command indices, and the countdown sequences for stop, disable, re-arm and load precedence.

// File: rtl/stat_pkg.sv
package stat_pkg;
    typedef enum logic [1:0] {
        LIM_OFF  = 2'd0,
        LIM_RUN  = 2'd1,
        LIM_DONE = 2'd2
    } lim_state_e;
endpackage

// File: rtl/stat_bucket_sel.sv
module stat_bucket_sel #(
    parameter int NUM_REQ = 4,
    parameter int ID_W    = 8,
    localparam int BKT_W  = $clog2(NUM_REQ + 1)
) (
    input  logic             ev_wb,
    input  logic             ev_dev,
    input  logic [ID_W-1:0]  ev_id,
    output logic [BKT_W-1:0] bucket
);
    // Writeback wins over device flag; device goes to the extra bucket.
    always_comb begin
        if (ev_wb) begin
            bucket = '0;
        end else if (ev_dev) begin
            bucket = BKT_W'(NUM_REQ);
        end else begin
            bucket = BKT_W'(ev_id % ID_W'(NUM_REQ));
        end
    end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank #(
    parameter int NUM_REQ = 4,
    parameter int NUM_CMD = 4,
    parameter int CNT_W   = 32,
    localparam int CMD_W  = (NUM_CMD > 1) ? $clog2(NUM_CMD) : 1,
    localparam int BKT_W  = $clog2(NUM_REQ + 1),
    localparam int NB     = NUM_REQ + 1,
    localparam int TOTAL  = 2 * NUM_CMD * NB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic             inc_miss,
    input  logic [CMD_W-1:0] inc_cmd,
    input  logic [BKT_W-1:0] inc_bucket,
    input  logic             rd_en,
    input  logic             rd_miss,
    input  logic [CMD_W-1:0] rd_cmd,
    input  logic [BKT_W-1:0] rd_bucket,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data
);
    function automatic int flat_idx(logic m, logic [CMD_W-1:0] c, logic [BKT_W-1:0] b);
        return ((m ? NUM_CMD : 0) + int'(c)) * NB + int'(b);
    endfunction

    function automatic logic in_range(logic [CMD_W-1:0] c, logic [BKT_W-1:0] b);
        return (int'(c) < NUM_CMD) && (int'(b) < NB);
    endfunction

    logic [CNT_W-1:0] cnt [TOTAL];
    int               wr_idx;
    int               rd_idx;
    logic             wr_ok;
    logic             rd_ok;

    always_comb begin
        wr_idx = flat_idx(inc_miss, inc_cmd, inc_bucket);
        wr_ok  = inc_en && in_range(inc_cmd, inc_bucket);
        rd_idx = flat_idx(rd_miss, rd_cmd, rd_bucket);
        rd_ok  = in_range(rd_cmd, rd_bucket);
    end

    for (genvar g = 0; g < TOTAL; g++) begin : g_cnt
        logic bump;
        assign bump = wr_ok && (wr_idx == g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt[g] <= '0;
            end else if (bump && (cnt[g] != '1)) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_ok ? cnt[rd_idx] : '0;
            end
        end
    end
endmodule

// File: rtl/stat_miss_limit.sv
module stat_miss_limit
    import stat_pkg::*;
#(
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lim_load,
    input  logic [LIMIT_W-1:0] lim_value,
    input  logic               miss_ev,
    output lim_state_e         lim_state,
    output logic               stop_pulse
);
    lim_state_e         state_nx;
    logic [LIMIT_W-1:0] remain;
    logic [LIMIT_W-1:0] remain_nx;

    always_comb begin
        state_nx  = lim_state;
        remain_nx = remain;
        if (lim_load) begin
            state_nx  = (lim_value != '0) ? LIM_RUN : LIM_OFF;
            remain_nx = lim_value;
        end else begin
            unique case (lim_state)
                LIM_OFF:  state_nx = LIM_OFF;
                LIM_RUN: begin
                    if (miss_ev) begin
                        remain_nx = remain - 1'b1;
                        if (remain == LIMIT_W'(1)) begin
                            state_nx = LIM_DONE;
                        end
                    end
                end
                LIM_DONE: state_nx = LIM_DONE;
                default:  state_nx = LIM_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_state <= LIM_OFF;
            remain    <= '0;
        end else begin
            lim_state <= state_nx;
            remain    <= remain_nx;
        end
    end

    // Output register: pulse on the RUN -> DONE transition only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pulse <= 1'b0;
        end else begin
            stop_pulse <= (lim_state == LIM_RUN) && (state_nx == LIM_DONE);
        end
    end
endmodule

// File: rtl/stat_hitmiss_counter.sv
module stat_hitmiss_counter
    import stat_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int NUM_CMD = 4,
    parameter int CNT_W   = 32,
    parameter int ID_W    = 8,
    parameter int LIMIT_W = 32,
    localparam int CMD_W  = (NUM_CMD > 1) ? $clog2(NUM_CMD) : 1,
    localparam int BKT_W  = $clog2(NUM_REQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic               ev_miss,
    input  logic [CMD_W-1:0]   ev_cmd,
    input  logic               ev_wb,
    input  logic               ev_dev,
    input  logic [ID_W-1:0]    ev_id,
    input  logic               lim_load,
    input  logic [LIMIT_W-1:0] lim_value,
    input  logic               rd_en,
    input  logic               rd_miss,
    input  logic [CMD_W-1:0]   rd_cmd,
    input  logic [BKT_W-1:0]   rd_bucket,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data,
    output logic               stop_pulse
);
    logic [BKT_W-1:0] sel_bucket;
    logic             miss_ev;
    lim_state_e       lim_state;

    assign miss_ev = ev_valid && ev_miss;

    stat_bucket_sel #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_sel (
        .ev_wb  (ev_wb),
        .ev_dev (ev_dev),
        .ev_id  (ev_id),
        .bucket (sel_bucket)
    );

    stat_counter_bank #(.NUM_REQ(NUM_REQ), .NUM_CMD(NUM_CMD), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_en     (ev_valid),
        .inc_miss   (ev_miss),
        .inc_cmd    (ev_cmd),
        .inc_bucket (sel_bucket),
        .rd_en      (rd_en),
        .rd_miss    (rd_miss),
        .rd_cmd     (rd_cmd),
        .rd_bucket  (rd_bucket),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    stat_miss_limit #(.LIMIT_W(LIMIT_W)) u_lim (
        .clk        (clk),
        .rst_n      (rst_n),
        .lim_load   (lim_load),
        .lim_value  (lim_value),
        .miss_ev    (miss_ev),
        .lim_state  (lim_state),
        .stop_pulse (stop_pulse)
    );
endmodule

// File: rtl/stat_hitmiss_checker.sv
module stat_hitmiss_checker
    import stat_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int LIMIT_W = 32,
    localparam int BKT_W  = $clog2(NUM_REQ + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ev_valid,
    input logic               ev_wb,
    input logic               ev_dev,
    input logic [BKT_W-1:0]   sel_bucket,
    input logic               rd_en,
    input logic               rd_valid,
    input logic               lim_load,
    input logic [LIMIT_W-1:0] lim_value,
    input logic               miss_ev,
    input lim_state_e         lim_state,
    input logic               stop_pulse
);
    assert_wb_bucket_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_wb) |-> (sel_bucket == '0));

    assert_dev_bucket_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_wb && ev_dev) |-> (sel_bucket == BKT_W'(NUM_REQ)));

    assert_id_bucket_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_wb && !ev_dev) |-> (int'(sel_bucket) < NUM_REQ));

    assert_read_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_read_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_stop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    assert_stop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_pulse) |-> $past(lim_state == LIM_RUN && miss_ev && !lim_load));

    assert_zero_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_load && lim_value == '0) |=> (lim_state == LIM_OFF));

    assert_off_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_state == LIM_OFF && !lim_load) |=> (lim_state == LIM_OFF));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_state == LIM_DONE && !lim_load) |=> (lim_state == LIM_DONE && !stop_pulse));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_load && lim_value != '0) |=> (lim_state == LIM_RUN && !stop_pulse));
endmodule

bind stat_hitmiss_counter stat_hitmiss_checker #(
    .NUM_REQ(NUM_REQ),
    .LIMIT_W(LIMIT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_wb      (ev_wb),
    .ev_dev     (ev_dev),
    .sel_bucket (sel_bucket),
    .rd_en      (rd_en),
    .rd_valid   (rd_valid),
    .lim_load   (lim_load),
    .lim_value  (lim_value),
    .miss_ev    (miss_ev),
    .lim_state  (lim_state),
    .stop_pulse (stop_pulse)
);

// File: tb/tb_stat_hitmiss_counter.sv
module tb_stat_hitmiss_counter;
    localparam int NREQ  = 3;
    localparam int NCMD  = 3;
    localparam int CW    = 8;
    localparam int IW    = 6;
    localparam int LW    = 16;
    localparam int CMDW  = $clog2(NCMD);
    localparam int BKTW  = $clog2(NREQ + 1);
    localparam int NB    = NREQ + 1;
    localparam int CMAX  = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_valid = 1'b0, ev_miss = 1'b0, ev_wb = 1'b0, ev_dev = 1'b0;
    logic [CMDW-1:0] ev_cmd = '0;
    logic [IW-1:0]   ev_id = '0;
    logic            lim_load = 1'b0;
    logic [LW-1:0]   lim_value = '0;
    logic            rd_en = 1'b0, rd_miss = 1'b0;
    logic [CMDW-1:0] rd_cmd = '0;
    logic [BKTW-1:0] rd_bucket = '0;
    logic            rd_valid;
    logic [CW-1:0]   rd_data;
    logic            stop_pulse;

    int checks = 0;
    int failures = 0;
    int stop_cnt = 0;
    bit finished = 0;
    int model [2][4][NB];

    always #5 clk = ~clk;

    stat_hitmiss_counter #(
        .NUM_REQ(NREQ), .NUM_CMD(NCMD), .CNT_W(CW), .ID_W(IW), .LIMIT_W(LW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_miss(ev_miss),
        .ev_cmd(ev_cmd), .ev_wb(ev_wb), .ev_dev(ev_dev), .ev_id(ev_id),
        .lim_load(lim_load), .lim_value(lim_value), .rd_en(rd_en),
        .rd_miss(rd_miss), .rd_cmd(rd_cmd), .rd_bucket(rd_bucket),
        .rd_valid(rd_valid), .rd_data(rd_data), .stop_pulse(stop_pulse)
    );

    always @(posedge clk) if (rst_n && stop_pulse) stop_cnt++;

    function automatic int exp_bucket(bit wb, bit dev, int id);
        if (wb) return 0;
        if (dev) return NREQ;
        return id % NREQ;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ev(bit m, int c, bit wb, bit dev, int id, bit ld = 0, int lv = 0);
        int b;
        @(negedge clk);
        ev_valid = 1; ev_miss = m; ev_cmd = CMDW'(c); ev_wb = wb; ev_dev = dev;
        ev_id = IW'(id); lim_load = ld; lim_value = LW'(lv);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 0; lim_load = 0;
        b = exp_bucket(wb, dev, id % (1 << IW));
        if (c < NCMD && model[m][c][b] < CMAX) model[m][c][b]++;
    endtask

    task automatic load_limit(int v);
        @(negedge clk);
        lim_load = 1; lim_value = LW'(v);
        @(posedge clk);
        @(negedge clk);
        lim_load = 0;
    endtask

    task automatic rd_check(bit m, int c, int b, string req);
        int exp;
        @(negedge clk);
        rd_en = 1; rd_miss = m; rd_cmd = CMDW'(c); rd_bucket = BKTW'(b);
        @(posedge clk);
        @(negedge clk);
        rd_en = 0;
        exp = (c < NCMD) ? model[m][c][b] : 0;
        check(rd_valid === 1'b1, {req, " rd_valid"}, int'(rd_valid), 1);
        check(rd_data === CW'(exp), req, int'(rd_data), exp);
    endtask

    task automatic rd_all(string req);
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++)
                for (int b = 0; b < NB; b++)
                    rd_check(m[0], c, b, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s;
        s = 0;
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 4; c++)
                for (int b = 0; b < NB; b++) model[m][c][b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(stop_pulse === 1'b0, "R10 stop low", int'(stop_pulse), 0);
        check(rd_valid === 1'b0, "R10 rd_valid low", int'(rd_valid), 0);
        rst_n = 1;
        rd_all("R10 zero after reset");

        // Directed routing
        ev(1, 1, 1, 1, 7);                 // R1 writeback miss, device flag ignored
        ev(0, 1, 1, 0, 2);                 // R1 writeback hit
        rd_check(1, 1, 0, "R1 wb miss bucket 0");
        rd_check(0, 1, 0, "R1 wb hit bucket 0");
        ev(0, 2, 0, 1, 1);                 // R2 device
        rd_check(0, 2, NREQ, "R2 device bucket");
        ev(1, 0, 0, 0, 5);                 // R3 id 5 -> bucket 2
        ev(1, 0, 0, 0, 63);                // R3 id 63 -> bucket 0
        rd_check(1, 0, 2, "R3 wrap id 5");
        rd_check(1, 0, 0, "R3 wrap id 63");
        rd_check(0, 0, 2, "R4 hit counter untouched by miss");
        ev(1, 3, 0, 0, 1);                 // R4 invalid cmd ignored
        rd_all("R4 invalid cmd ignored");
        rd_check(1, 3, 1, "R6 out-of-range cmd reads zero");

        // Seeded random stream (countdown still off after reset)
        void'($urandom(32'd20240611));
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            ev(r[0], (r >> 1) & 3, ((r >> 3) & 3) == 0, ((r >> 5) & 3) == 0, (r >> 7) & 63);
        end
        rd_all("R4 random stream");
        check(stop_cnt == 0, "R10 countdown off after reset", stop_cnt, 0);

        // Saturation
        for (int i = 0; i < CMAX + 5; i++) ev(0, 2, 1, 0, 0);
        rd_check(0, 2, 0, "R5 saturate");

        // Countdown
        load_limit(3);
        ev(0, 0, 0, 0, 0);
        check(stop_pulse === 1'b0, "R7 hit no decrement", int'(stop_pulse), 0);
        ev(1, 0, 0, 0, 0);
        ev(1, 0, 0, 0, 0);
        check(stop_pulse === 1'b0, "R7 not yet", int'(stop_pulse), 0);
        ev(1, 0, 0, 0, 0);
        check(stop_pulse === 1'b1, "R7 stop on third miss", int'(stop_pulse), 1);
        ev(1, 0, 0, 0, 0);
        check(stop_pulse === 1'b0, "R7 one cycle", int'(stop_pulse), 0);
        ev(1, 0, 0, 0, 0);
        check(stop_cnt == 1, "R9 no refire", stop_cnt, 1);
        load_limit(0);
        for (int i = 0; i < 5; i++) ev(1, 1, 0, 0, i);
        check(stop_cnt == 1, "R8 zero disables", stop_cnt, 1);
        load_limit(2);
        ev(1, 0, 0, 0, 0);
        check(stop_pulse === 1'b0, "R9 rearm first", int'(stop_pulse), 0);
        ev(1, 0, 0, 0, 0);
        check(stop_pulse === 1'b1, "R9 rearm stop", int'(stop_pulse), 1);
        ev(1, 2, 0, 0, 1, 1, 2);           // R11 load with miss
        check(stop_pulse === 1'b0, "R11 load wins", int'(stop_pulse), 0);
        ev(1, 2, 0, 0, 1);
        check(stop_pulse === 1'b0, "R11 first miss after load", int'(stop_pulse), 0);
        ev(1, 2, 0, 0, 1);
        check(stop_pulse === 1'b1, "R11 stop on second", int'(stop_pulse), 1);
        rd_check(1, 2, 1, "R11 miss still counted");
        check(stop_cnt == 3, "R9 total stops", stop_cnt, 3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule